// File: doc/BRIEF.md
# Two-Level Nested Interrupt Acceptance Unit

This unit decides, at each instruction boundary of a small 8-bit core, whether a pending interrupt is taken. It gathers five request sources: two external pins, which it synchronizes and edge- or level-detects itself, and three flags from on-chip peripherals (timer 0, timer 1, serial). It gates them with an enable register that has a global enable bit and a priority register. When a source is taken, it emits a one-cycle accept pulse with the vector address and a clear pulse for that source's flag. It also pushes the new level onto a two-entry in-service stack.

When a request appears while the core is idle, the unit only wakes the core. The vector is taken at a later boundary. After a return from interrupt, and after a wake-up, one boundary passes with no acceptance, so the core always runs at least one more instruction. Opcode execution, stacking of the program counter and the peripherals themselves belong to the core and are not part of this unit.

Top module: `irq_nest_ctrl`

## Requirements
- R1: No source is accepted while bit 7 of `en_i` (global enable) is 0.
- R2: Source slots are 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1 and 4 = serial. Slot i is eligible only when `en_i[i]` is set and its request is pending. `per_req_i` bits 0, 1 and 2 feed slots 1, 3 and 4.
- R3: Among the eligible, unblocked slots, the lowest slot index wins, whatever the priorities. The vector is 0x03 + 8 * slot.
- R4: Slot i has priority 1 when `pri_i[i]` is set and 0 otherwise. A slot is blocked when the current in-service level is greater than or equal to its priority. A low handler yields only to a high request, and a high handler yields to nothing.
- R5: `cur_lvl_o` reads 2'b11 when nothing is in service, 2'b00 for low and 2'b01 for high. An acceptance pushes the new level, and `reti_i` pops one entry. Depth is at most two.
- R6: The first boundary that comes with, or follows, a `reti_i` pulse accepts nothing. The boundary after it may accept.
- R7: While `cpu_idle_i` is high, every cycle is an evaluation step. A winning request then raises `wake_o` for one cycle with no accept and no stack change, and the next boundary accepts nothing.
- R8: On acceptance `clr_o` pulses with exactly the winning slot's bit, but only when that slot's bit of AUTO_CLR is set (default 5'b01111, so serial is not cleared). An edge-latched external flag is cleared by its acceptance.
- R9: With `ext_edge_i[k]` set, a falling edge on `ext_n_i[k]` latches a pending flag that stays set after the pin returns high. The flag shows on `ext_pend_o[k]` three cycles after the pin changes. Steady or rising pins latch nothing.
- R10: With `ext_edge_i[k]` clear, `ext_pend_o[k]` is the inverted, synchronized pin level.
- R11: `take_o`, `vec_o`, `clr_o` and `wake_o` are registered. They appear in the cycle after the step that produced them. After reset all pulses are low, `cur_lvl_o` is 2'b11 and `ext_pend_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n_i | input | 2 | External request pins, active low |
| ext_edge_i | input | 2 | Per-pin mode: 1 edge latched, 0 level |
| per_req_i | input | 3 | Peripheral request flags (timer 0, timer 1, serial) |
| en_i | input | 8 | Enable register: bits 4..0 per slot, bit 7 global |
| pri_i | input | 5 | Priority register, one bit per slot |
| cpu_idle_i | input | 1 | Core is in idle mode |
| insn_end_i | input | 1 | Instruction boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | Accept pulse |
| vec_o | output | 8 | Vector address of the accepted slot |
| clr_o | output | 5 | Request-flag clear pulse, one bit per slot |
| wake_o | output | 1 | Leave-idle pulse |
| cur_lvl_o | output | 2 | Current in-service level |
| ext_pend_o | output | 2 | Pending state of the external requests |

## Verification
The bench targets the places where the fixed scan order and the level check interact. A pending high-priority request in a later slot must lose to an earlier low one when nothing is in service. A design that sorted by priority would vector to the wrong address. It pushes two nested levels and returns from both. A stack that failed to restore the low level would let a second low request pre-empt its peer, or would keep blocking once both handlers have returned. The single-boundary hold after a return and after an idle wake-up is probed on both sides. A design that vectored while waking, or that forgot the hold, would show an early `take_o`. Edge latching is checked across the pin returning high, and auto-clear is checked on a slot that has it disabled.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int NSRC = 5;
    localparam int NPER = 3;
    localparam int NEXT = 2;

    typedef logic [1:0] lvl_t;
    localparam lvl_t LVL_NONE = 2'b11;
    localparam lvl_t LVL_LOW  = 2'b00;
    localparam lvl_t LVL_HIGH = 2'b01;

    // Slot layout: ext0, tmr0, ext1, tmr1, serial
    function automatic logic [NSRC-1:0] merge_req(input logic [NEXT-1:0] ext,
                                                  input logic [NPER-1:0] per);
        return {per[2], per[1], ext[1], per[0], ext[0]};
    endfunction

    function automatic logic [NEXT-1:0] ext_slots(input logic [NSRC-1:0] v);
        return {v[2], v[0]};
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    input  logic edge_mode_i,
    input  logic ack_i,
    output logic pend_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic flag;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic    fall;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_n_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        fall      = st_q.prev & ~st_q.s2;
        if (edge_mode_i) begin
            st_d.flag = fall | (st_q.flag & ~ack_i);
        end else begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = edge_mode_i ? st_q.flag : ~st_q.s2;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NSRC  = 5,
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] pri_i,
    input  logic            busy_i,
    input  logic            top_hi_i,
    output logic            hit_o,
    output logic [IDXW-1:0] idx_o,
    output logic            hit_hi_o
);

    logic [NSRC-1:0] cand;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            // blocked when level in service >= own priority
            cand[i] = req_i[i] & en_i[i] & ~(busy_i & (~pri_i[i] | top_hi_i));
        end
        hit_o    = 1'b0;
        idx_o    = '0;
        hit_hi_o = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit_o    = 1'b1;
                idx_o    = IDXW'(i);
                hit_hi_o = pri_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
    import irq_nest_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic push_hi_i,
    input  logic pop_i,
    output logic busy_o,
    output logic top_hi_o,
    output lvl_t cur_lvl_o
);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [DEPTH-1:0] hi;
    } stk_st_t;

    stk_st_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (push_i && (stk_q.cnt < CW'(DEPTH))) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (int'(stk_q.cnt) == i) begin
                    stk_d.hi[i] = push_hi_i;
                end
            end
            stk_d.cnt = stk_q.cnt + CW'(1);
        end else if (pop_i && (stk_q.cnt != '0)) begin
            stk_d.cnt = stk_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    always_comb begin
        top_hi_o = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(stk_q.cnt) == i + 1) begin
                top_hi_o = stk_q.hi[i];
            end
        end
        busy_o    = (stk_q.cnt != '0);
        cur_lvl_o = busy_o ? {1'b0, top_hi_o} : LVL_NONE;
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int             VEC_W    = 8,
    parameter int             VEC_BASE = 3,
    parameter int             VEC_STEP = 8,
    parameter int             EN_W     = 8,
    parameter int             EA_BIT   = 7,
    parameter logic [NSRC-1:0] AUTO_CLR = 5'b01111,
    localparam int            IDXW     = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEXT-1:0]  ext_n_i,
    input  logic [NEXT-1:0]  ext_edge_i,
    input  logic [NPER-1:0]  per_req_i,
    input  logic [EN_W-1:0]  en_i,
    input  logic [NSRC-1:0]  pri_i,
    input  logic             cpu_idle_i,
    input  logic             insn_end_i,
    input  logic             reti_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [NSRC-1:0]  clr_o,
    output logic             wake_o,
    output logic [1:0]       cur_lvl_o,
    output logic [NEXT-1:0]  ext_pend_o
);

    typedef struct packed {
        logic             take;
        logic [VEC_W-1:0] vec;
        logic [NSRC-1:0]  clr;
        logic             wake;
        logic             hold;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic [NSRC-1:0] req_all;
    logic [NEXT-1:0] ext_ack;
    logic            busy, top_hi, hit, hit_hi;
    logic [IDXW-1:0] hit_idx;
    logic            push;
    logic            step, held;
    lvl_t            lvl;
    logic            unused_en;

    assign unused_en = ^en_i[EA_BIT-1:NSRC];

    // external pins: one synchronizer / detector per pin
    for (genvar k = 0; k < NEXT; k++) begin : g_pin
        irq_pin_sync u_pin (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_n_i     (ext_n_i[k]),
            .edge_mode_i (ext_edge_i[k]),
            .ack_i       (ext_ack[k]),
            .pend_o      (ext_pend_o[k])
        );
    end

    assign req_all = merge_req(ext_pend_o, per_req_i);

    irq_pick #(.NSRC(NSRC)) u_pick (
        .req_i    (req_all),
        .en_i     (en_i[NSRC-1:0]),
        .pri_i    (pri_i),
        .busy_i   (busy),
        .top_hi_i (top_hi),
        .hit_o    (hit),
        .idx_o    (hit_idx),
        .hit_hi_o (hit_hi)
    );

    irq_lvl_stack #(.DEPTH(2)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .push_hi_i (hit_hi),
        .pop_i     (reti_i),
        .busy_o    (busy),
        .top_hi_o  (top_hi),
        .cur_lvl_o (lvl)
    );

    always_comb begin
        step       = insn_end_i | cpu_idle_i;
        held       = ctl_q.hold | reti_i;
        ctl_d      = ctl_q;
        ctl_d.take = 1'b0;
        ctl_d.clr  = '0;
        ctl_d.wake = 1'b0;
        ctl_d.hold = held;
        push       = 1'b0;
        if (step) begin
            ctl_d.hold = 1'b0;
            if (!held && en_i[EA_BIT] && hit) begin
                if (cpu_idle_i) begin
                    ctl_d.wake = 1'b1;
                    ctl_d.hold = 1'b1;
                end else begin
                    ctl_d.take = 1'b1;
                    ctl_d.vec  = VEC_W'(VEC_BASE + VEC_STEP * int'(hit_idx));
                    for (int i = 0; i < NSRC; i++) begin
                        ctl_d.clr[i] = AUTO_CLR[i] && (int'(hit_idx) == i);
                    end
                    push = 1'b1;
                end
            end
        end
        ext_ack = ext_slots(ctl_d.clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign take_o    = ctl_q.take;
    assign vec_o     = ctl_q.vec;
    assign clr_o     = ctl_q.clr;
    assign wake_o    = ctl_q.wake;
    assign cur_lvl_o = lvl;

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] en_i,
    input logic       cpu_idle_i,
    input logic       insn_end_i,
    input logic       reti_i,
    input logic       take_o,
    input logic [4:0] clr_o,
    input logic       wake_o,
    input logic [1:0] cur_lvl_o
);

    // R1
    ea_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(en_i[7]));

    // R4
    high_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl_o == 2'b01) |=> !take_o);

    // R5
    lvl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lvl_o != 2'b10);

    // R6
    reti_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && insn_end_i) |=> !take_o);

    // R7
    wake_novec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (!take_o && $past(cpu_idle_i)));

    // R8
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o) && ((clr_o == 5'b0) || take_o));

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .cpu_idle_i (cpu_idle_i),
    .insn_end_i (insn_end_i),
    .reti_i     (reti_i),
    .take_o     (take_o),
    .clr_o      (clr_o),
    .wake_o     (wake_o),
    .cur_lvl_o  (cur_lvl_o)
);

// File: tb/test_irq_nest_ctrl.sv
`timescale 1ns/1ps
module test_irq_nest_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_n = 2'b11, ext_edge = 2'b00;
    logic [2:0] per = 3'b000;
    logic [7:0] en = 8'h00;
    logic [4:0] pri = 5'h00;
    logic       idle = 1'b0, iend = 1'b0, reti = 1'b0;
    logic       take, wake;
    logic [7:0] vec;
    logic [4:0] clr;
    logic [1:0] lvl, pend;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    localparam logic [4:0] AUTO = 5'b01111;

    always #4 clk = ~clk;

    irq_nest_ctrl i_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_n_i(ext_n), .ext_edge_i(ext_edge),
        .per_req_i(per), .en_i(en), .pri_i(pri), .cpu_idle_i(idle),
        .insn_end_i(iend), .reti_i(reti), .take_o(take), .vec_o(vec),
        .clr_o(clr), .wake_o(wake), .cur_lvl_o(lvl), .ext_pend_o(pend)
    );

    // en, pri, per, ext pins low, take, vec
    localparam int NT = 9;
    localparam logic [26:0] TBL [NT] = '{
        {8'h00, 5'h00, 3'b111, 2'b00, 1'b0, 8'h00},
        {8'h1F, 5'h00, 3'b111, 2'b00, 1'b0, 8'h00},
        {8'h9F, 5'h00, 3'b001, 2'b00, 1'b1, 8'h0B},
        {8'h9F, 5'h00, 3'b110, 2'b00, 1'b1, 8'h1B},
        {8'h97, 5'h00, 3'b110, 2'b00, 1'b1, 8'h23},
        {8'h9F, 5'h00, 3'b111, 2'b01, 1'b1, 8'h03},
        {8'h9F, 5'h10, 3'b101, 2'b00, 1'b1, 8'h0B},
        {8'h9E, 5'h00, 3'b000, 2'b11, 1'b1, 8'h13},
        {8'h80, 5'h00, 3'b111, 2'b11, 1'b0, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step_once(input logic with_reti);
        @(negedge clk);
        iend = 1'b1;
        reti = with_reti;
        @(negedge clk);
        iend = 1'b0;
        reti = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        en = 8'h00; per = 3'b000; ext_n = 2'b11;
        step_once(1'b1);
        step_once(1'b1);
        settle(3);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        // R11 reset state
        chk("R11 take", take, 0);
        chk("R11 wake", wake, 0);
        chk("R11 lvl", lvl, 2'b11);
        chk("R11 pend", pend, 0);

        // R1 R2 R3 R8 R10 table
        for (int t = 0; t < NT; t++) begin
            logic [26:0] e;
            int idx;
            logic [4:0] eclr;
            e = TBL[t];
            en = e[26:19]; pri = e[18:14]; per = e[13:11]; ext_n = ~e[10:9];
            settle(3);
            step_once(1'b0);
            idx = (int'(e[7:0]) - 3) / 8;
            eclr = e[8] ? (5'(AUTO[idx]) << idx) : 5'b0;
            chk($sformatf("R1 R2 take row %0d", t), take, e[8]);
            if (e[8]) begin
                chk($sformatf("R3 vec row %0d", t), vec, e[7:0]);
                chk($sformatf("R4 lvl row %0d", t), lvl, {1'b0, pri[idx]});
            end
            chk($sformatf("R8 clr row %0d", t), clr, eclr);
            drain();
        end

        // R4 R5 nesting
        en = 8'h9A; pri = 5'h10; per = 3'b001;
        step_once(1'b0);
        chk("R5 low take", {take, vec, lvl}, {1'b1, 8'h0B, 2'b00});
        per = 3'b010;
        step_once(1'b0);
        chk("R4 low blocks low", take, 0);
        per = 3'b110;
        step_once(1'b0);
        chk("R4 high preempts", {take, vec, lvl}, {1'b1, 8'h23, 2'b01});
        step_once(1'b0);
        chk("R4 high not preempted", take, 0);
        per = 3'b010;
        step_once(1'b1);
        chk("R5 pop to low", {take, lvl}, {1'b0, 2'b00});
        step_once(1'b0);
        chk("R4 restored low blocks", take, 0);
        step_once(1'b1);
        chk("R5 pop to none", {take, lvl}, {1'b0, 2'b11});
        step_once(1'b0);
        chk("R5 accept after pops", {take, vec, lvl}, {1'b1, 8'h1B, 2'b00});
        drain();

        // R6 reti without coincident boundary
        en = 8'h82; per = 3'b001;
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
        step_once(1'b0);
        chk("R6 held boundary", take, 0);
        step_once(1'b0);
        chk("R6 next boundary", {take, vec}, {1'b1, 8'h0B});
        drain();

        // R7 idle wake
        en = 8'h82; per = 3'b000; idle = 1'b1;
        settle(2);
        chk("R7 idle no request", wake, 0);
        per = 3'b001;
        settle(1);
        chk("R7 wake", {wake, take, lvl}, {1'b1, 1'b0, 2'b11});
        idle = 1'b0;
        step_once(1'b0);
        chk("R7 hold after wake", take, 0);
        step_once(1'b0);
        chk("R7 take after hold", {take, vec}, {1'b1, 8'h0B});
        drain();

        // R9 edge latch, R8 clear
        ext_edge = 2'b01; en = 8'h81;
        settle(3);
        chk("R9 no edge", pend[0], 0);
        ext_n = 2'b10;
        settle(3);
        chk("R9 fall latched", pend[0], 1);
        ext_n = 2'b11;
        settle(3);
        chk("R9 held after rise", pend[0], 1);
        step_once(1'b0);
        chk("R8 edge take", {take, vec, clr}, {1'b1, 8'h03, 5'b00001});
        chk("R8 edge flag cleared", pend[0], 0);
        drain();
        settle(3);
        chk("R9 rise no latch", pend[0], 0);

        // R10 level mode
        ext_edge = 2'b00;
        ext_n = 2'b01;
        settle(3);
        chk("R10 level low", pend[1], 1);
        ext_n = 2'b11;
        settle(3);
        chk("R10 level high", pend[1], 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule